// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects completion events from sixteen DMA channels and turns them into one interrupt line. Every channel reports three kinds of event as single-cycle pulses: a half-way point of the current block, the end of one transfer item, and the end of the whole chained transfer. Each pulse latches a pending bit. Software chooses which pending bits may raise the interrupt by setting matching enable bits. The interrupt line is high while any bit is both pending and enabled.

Software reaches the enable and pending words, plus a read-only word that shows which channels are busy, over a plain 32-bit register port. The port has an address, a write strobe, write data and read data. Reads are combinational and writes take effect at the clock edge. There is no flow control on this port. A write always completes in its cycle, so it has no valid/ready pair. The pending words are write-one-to-clear. To acknowledge, software writes back the value it read, and that clears exactly the events it has seen.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every enable and pending bit is 0 and irq_out is low.
- R2: An event pulse for channel n sets one pending bit at bit 4*(n mod 8)+k of the pending word for group n/8. The slot bit k is 0 for half-way, 1 for item end and 2 for chain end. The bit is set whatever the enable setting, and it reads back from the cycle after the pulse.
- R3: A write to a pending word clears every bit where the write data is 1 and leaves the other bits unchanged. The pending word for channels 0-7 is at 0x10 and the one for channels 8-15 is at 0x14. Without events or writes, the pending bits hold.
- R4: The enable words are at 0x00 (channels 0-7) and 0x04 (channels 8-15), and each takes the written value from the next cycle. Bit 3 of every 4-bit slot reads 0 in both enable and pending words, and writes to it are ignored.
- R5: irq_out is high exactly when some bit is set in both a pending word and the matching enable word.
- R6: When an event and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R7: Address 0x30 reads chan_busy in bits 15:0 and zero above. Writes to it change no enable or pending bit.
- R8: Any address other than 0x00, 0x04, 0x10, 0x14 and 0x30 reads 0. Writes to such an address change no state.
- R9: reg_rdata follows reg_addr and the stored state in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_half | input | 16 | Half-way event pulse, one bit per channel |
| evt_item | input | 16 | Item-end event pulse, one bit per channel |
| evt_chain | input | 16 | Chain-end event pulse, one bit per channel |
| chan_busy | input | 16 | Busy flag per channel, shown at 0x30 |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Event pulses and register writes are applied at a rising edge, and their effect on the stored words and on irq_out is due one edge later. Read data and the busy word are combinational, so they are due in the same cycle as the address. The bench drives every input on the falling edge and lets one rising edge pass. It then moves its reference model forward and compares reg_rdata and irq_out shortly after the next falling edge. Collisions between events and clears are placed on the same edge on purpose, so the bench can check which side wins.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NUM_CH      = 16;
  localparam int CH_PER_WORD = 8;
  localparam int SLOT_W      = 4;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int NUM_WORDS   = NUM_CH / CH_PER_WORD;
  localparam int WORD_STRIDE = 4;
  // register offsets; slot layout is decoded by software so it stays fixed
  localparam int EN_BASE   = 'h00;
  localparam int PEND_BASE = 'h10;
  localparam int STAT_OFF  = 'h30;
  // slot bit positions
  localparam int BIT_HALF  = 0;
  localparam int BIT_ITEM  = 1;
  localparam int BIT_CHAIN = 2;
endpackage

// File: rtl/dmairq_word.sv
module dmairq_word
  import dmairq_pkg::*;
#(
  parameter int CH     = CH_PER_WORD,
  parameter int SW     = SLOT_W,
  parameter int WORD_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH-1:0]     ev_half,
  input  logic [CH-1:0]     ev_item,
  input  logic [CH-1:0]     ev_chain,
  input  logic              en_wr,
  input  logic              pend_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] pend_q,
  output logic              irq_any
);
  logic [WORD_W-1:0] set_vec;
  logic [WORD_W-1:0] impl_mask;

  // each slot: event bits placed at their fixed positions, upper bits reserved
  for (genvar c = 0; c < CH; c++) begin : g_slot
    always_comb begin
      set_vec[c*SW +: SW]              = '0;
      set_vec[c*SW + BIT_HALF]         = ev_half[c];
      set_vec[c*SW + BIT_ITEM]         = ev_item[c];
      set_vec[c*SW + BIT_CHAIN]        = ev_chain[c];
      impl_mask[c*SW +: SW]            = '0;
      impl_mask[c*SW + BIT_HALF]       = 1'b1;
      impl_mask[c*SW + BIT_ITEM]       = 1'b1;
      impl_mask[c*SW + BIT_CHAIN]      = 1'b1;
    end
  end

  if (CH * SW < WORD_W) begin : g_pad
    assign set_vec[WORD_W-1:CH*SW]   = '0;
    assign impl_mask[WORD_W-1:CH*SW] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata & impl_mask;
      // clear first, then set: a same-cycle event wins over the clear
      pend_q <= (pend_wr ? (pend_q & ~wdata) : pend_q) | set_vec;
    end
  end

  assign irq_any = |(en_q & pend_q);
endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux
  import dmairq_pkg::*;
#(
  parameter int NW  = NUM_WORDS,
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W
) (
  input  logic [AW-1:0]        addr,
  input  logic [NW-1:0][DW-1:0] en_w,
  input  logic [NW-1:0][DW-1:0] pend_w,
  input  logic [NCH-1:0]       busy,
  output logic [DW-1:0]        rdata
);
  logic [NW-1:0][DW-1:0] term;

  for (genvar w = 0; w < NW; w++) begin : g_sel
    always_comb begin
      term[w] = '0;
      if (addr == AW'(EN_BASE + w*WORD_STRIDE))   term[w] = en_w[w];
      if (addr == AW'(PEND_BASE + w*WORD_STRIDE)) term[w] = pend_w[w];
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NW; w++) rdata = rdata | term[w];
    if (addr == AW'(STAT_OFF)) rdata = DW'(busy);
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dmairq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_half,
  input  logic [NUM_CH-1:0] evt_item,
  input  logic [NUM_CH-1:0] evt_chain,
  input  logic [NUM_CH-1:0] chan_busy,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic [NUM_WORDS-1:0][DATA_W-1:0] en_all;
  logic [NUM_WORDS-1:0][DATA_W-1:0] pend_all;
  logic [NUM_WORDS-1:0]             word_irq;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic en_hit, pend_hit;
    assign en_hit   = reg_we && (reg_addr == ADDR_W'(EN_BASE + w*WORD_STRIDE));
    assign pend_hit = reg_we && (reg_addr == ADDR_W'(PEND_BASE + w*WORD_STRIDE));

    dmairq_word #(
      .CH(CH_PER_WORD), .SW(SLOT_W), .WORD_W(DATA_W)
    ) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_half (evt_half[w*CH_PER_WORD +: CH_PER_WORD]),
      .ev_item (evt_item[w*CH_PER_WORD +: CH_PER_WORD]),
      .ev_chain(evt_chain[w*CH_PER_WORD +: CH_PER_WORD]),
      .en_wr   (en_hit),
      .pend_wr (pend_hit),
      .wdata   (reg_wdata),
      .en_q    (en_all[w]),
      .pend_q  (pend_all[w]),
      .irq_any (word_irq[w])
    );
  end

  dmairq_rdmux #(
    .NW(NUM_WORDS), .NCH(NUM_CH), .DW(DATA_W), .AW(ADDR_W)
  ) u_rd (
    .addr  (reg_addr),
    .en_w  (en_all),
    .pend_w(pend_all),
    .busy  (chan_busy),
    .rdata (reg_rdata)
  );

  assign irq_out = |word_irq;
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk
  import dmairq_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_CH-1:0]         evt_half,
  input logic [NUM_CH-1:0]         evt_item,
  input logic [NUM_CH-1:0]         evt_chain,
  input logic [NUM_CH-1:0]         chan_busy,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic                      reg_we,
  input logic [DATA_W-1:0]         reg_wdata,
  input logic [DATA_W-1:0]         reg_rdata,
  input logic                      irq_out,
  input logic [NUM_WORDS*DATA_W-1:0] en_all,
  input logic [NUM_WORDS*DATA_W-1:0] pend_all
);
  logic any_evt, mapped;
  assign any_evt = |{evt_half, evt_item, evt_chain};
  assign mapped  = (reg_addr == ADDR_W'(EN_BASE)) || (reg_addr == ADDR_W'(EN_BASE + WORD_STRIDE)) ||
                   (reg_addr == ADDR_W'(PEND_BASE)) || (reg_addr == ADDR_W'(PEND_BASE + WORD_STRIDE)) ||
                   (reg_addr == ADDR_W'(STAT_OFF));

  // R2 / R6: each pulse leaves its bit set one edge later, clear or not
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int B = (n / CH_PER_WORD) * DATA_W + (n % CH_PER_WORD) * SLOT_W;
    p_half_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_half[n] |=> pend_all[B + BIT_HALF]);
    p_chain_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_chain[n] |=> pend_all[B + BIT_CHAIN]);
  end

  p_w1c_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(PEND_BASE) && !any_evt)
    |=> ((pend_all[DATA_W-1:0] & $past(reg_wdata)) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !any_evt) |=> ($stable(pend_all) && $stable(en_all)));

  p_rsv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != ADDR_W'(STAT_OFF)) |-> ((reg_rdata & 32'h8888_8888) == '0));

  p_no_en_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> !irq_out);

  p_no_pend_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all == '0) |-> !irq_out);

  p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(STAT_OFF)) |-> (reg_rdata == DATA_W'(chan_busy)));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == '0));

  p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !mapped && !any_evt) |=> ($stable(pend_all) && $stable(en_all)));
endmodule

bind dma_irq_agg dma_irq_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_half(evt_half), .evt_item(evt_item),
  .evt_chain(evt_chain), .chan_busy(chan_busy), .reg_addr(reg_addr),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_out(irq_out), .en_all(en_all), .pend_all(pend_all)
);

// File: tb/dma_irq_agg_tb.sv
`timescale 1ns/1ps
module dma_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt_half, evt_item, evt_chain, chan_busy;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_en [2];
  logic [31:0] m_pend [2];

  always #4 clk = ~clk;

  dma_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .evt_half(evt_half), .evt_item(evt_item),
    .evt_chain(evt_chain), .chan_busy(chan_busy), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [31:0] spread(input logic [15:0] h, i, c, input int w);
    logic [31:0] v = '0;
    for (int ch = 0; ch < 8; ch++) begin
      v[4*ch]     = h[8*w+ch];
      v[4*ch + 1] = i[8*w+ch];
      v[4*ch + 2] = c[8*w+ch];
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_en[0];
      8'h04: return m_en[1];
      8'h10: return m_pend[0];
      8'h14: return m_pend[1];
      8'h30: return {16'h0, chan_busy};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |((m_en[0] & m_pend[0]) | (m_en[1] & m_pend[1]));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive on falling edge, model after rising edge, clear on next fall
  task automatic cycle(input logic [15:0] h, i, c, input logic we,
                       input logic [7:0] a, input logic [31:0] d);
    evt_half = h; evt_item = i; evt_chain = c;
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    for (int w = 0; w < 2; w++) begin
      if (we && a == 8'(8'h10 + 4*w)) m_pend[w] = m_pend[w] & ~d;
      m_pend[w] = m_pend[w] | spread(h, i, c, w);
      if (we && a == 8'(4*w)) m_en[w] = d & 32'h7777_7777;
    end
    @(negedge clk);
    evt_half = '0; evt_item = '0; evt_chain = '0; reg_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp_rd(a));
    check({tag, " irq"}, {31'h0, irq_out}, {31'h0, exp_irq()});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    logic [7:0] addr_set [7];
    seed_init = $urandom(32'h5eed_0042);
    addr_set = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h30, 8'h08, 8'h20};
    m_en = '{32'h0, 32'h0}; m_pend = '{32'h0, 32'h0};
    rst_n = 1'b0; evt_half = '0; evt_item = '0; evt_chain = '0;
    chan_busy = '0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    // events during reset must not stick
    evt_half = 16'hFFFF;
    @(posedge clk);
    @(negedge clk);
    evt_half = '0; rst_n = 1'b1;
    #1;
    // R1: reset state
    rd_check("R1 en0", 8'h00);
    rd_check("R1 en1", 8'h04);
    rd_check("R1 pend0", 8'h10);
    rd_check("R1 pend1", 8'h14);

    // R2: channel 13 item end -> word 1 bit 21, with enable off, irq stays low
    cycle(16'h0, 16'h2000, 16'h0, 1'b0, 8'h00, 32'h0);
    rd_check("R2 ch13 item pend1", 8'h14);
    check("R2 ch13 bit21", reg_rdata, 32'h0020_0000);
    check("R5 irq low when disabled", {31'h0, irq_out}, 32'h0);
    // R2: channel 2 half + channel 7 chain -> word 0 bits 8 and 30
    cycle(16'h0004, 16'h0, 16'h0080, 1'b0, 8'h00, 32'h0);
    reg_addr = 8'h10; #1;
    check("R2 ch2 half ch7 chain", reg_rdata, 32'h4000_0100);

    // R4: reserved bits dropped on enable write; R5 irq rises next cycle
    cycle(16'h0, 16'h0, 16'h0, 1'b1, 8'h04, 32'hFFFF_FFFF);
    reg_addr = 8'h04; #1;
    check("R4 enable reserved bits", reg_rdata, 32'h7777_7777);
    check("R5 irq high", {31'h0, irq_out}, 32'h1);
    // R9: combinational read, address change visible same cycle
    reg_addr = 8'h14; #1;
    check("R9 same-cycle read", reg_rdata, 32'h0020_0000);

    // R3: write-one-to-clear, zeros leave bits
    cycle(16'h0, 16'h0, 16'h0, 1'b1, 8'h14, 32'h0020_0000);
    rd_check("R3 clear pend1", 8'h14);
    check("R5 irq low after clear", {31'h0, irq_out}, 32'h0);
    cycle(16'h0, 16'h0, 16'h0, 1'b1, 8'h10, 32'h0000_0100);
    reg_addr = 8'h10; #1;
    check("R3 partial clear", reg_rdata, 32'h4000_0000);

    // R6: event and clear on same bit, same edge
    cycle(16'h0, 16'h0, 16'h0080, 1'b1, 8'h10, 32'h4000_0000);
    reg_addr = 8'h10; #1;
    check("R6 event wins", reg_rdata, 32'h4000_0000);

    // R7: status read and ignored write
    chan_busy = 16'hA5C3;
    rd_check("R7 status", 8'h30);
    cycle(16'h0, 16'h0, 16'h0, 1'b1, 8'h30, 32'hFFFF_FFFF);
    rd_check("R7 write ignored en0", 8'h00);
    rd_check("R7 write ignored pend0", 8'h10);
    // R8: unmapped address
    cycle(16'h0, 16'h0, 16'h0, 1'b1, 8'h08, 32'hFFFF_FFFF);
    rd_check("R8 unmapped read", 8'h08);
    rd_check("R8 write ignored en1", 8'h04);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] h, i, c;
      logic        we;
      logic [7:0]  a, ra;
      logic [31:0] d;
      h  = 16'($urandom & $urandom & $urandom);
      i  = 16'($urandom & $urandom & $urandom);
      c  = 16'($urandom & $urandom & $urandom);
      we = ($urandom % 3) == 0;
      a  = addr_set[$urandom % 7];
      d  = $urandom;
      chan_busy = 16'($urandom);
      cycle(h, i, c, we, a, d);
      ra = addr_set[$urandom % 7];
      case (ra)
        8'h00, 8'h04: rd_check("R4 R5 random enable", ra);
        8'h10, 8'h14: rd_check("R2 R3 R6 random pending", ra);
        8'h30:        rd_check("R7 random status", ra);
        default:      rd_check("R8 random unmapped", ra);
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule